// File: doc/BRIEF.md
# Dual-Clock Bus-Master FIFO Bridge

This block moves 32-bit words between a bus-master port and a simple word-stream port on a separate card clock. The card clock is slower and asynchronous to the bus clock. In receive mode the card side pushes words into a clock-crossing FIFO. The master drains them with write cycles to consecutive word addresses, starting at a supplied base address. In transmit mode the master fetches words from memory with read cycles into a second clock-crossing FIFO, and the card side pops them in the same order.

Each FIFO reports full and empty in its own clock domain. The master throttles its bus cycles on those flags. Dropping an enable aborts any open cycle and flushes the matching FIFO in both domains. When both enables are low, the word index restarts at zero.

Top module: `bridge_dma`

## Requirements
- R1: After reset, `wb_cyc_o`, `wb_stb_o` and `wb_we_o` are low, `card_empty_o` and `bus_empty_o` are high, and `card_full_o` and `bus_full_o` are low.
- R2: The k-th word acknowledged since both enables were last low uses address `base_adr + 4*k`. The count continues across a change from receive to transmit mode while one enable stays high.
- R3: In receive mode each word is written with `wb_cyc_o`, `wb_stb_o` and `wb_we_o` high. Address and data stay stable until `wb_ack_i`. Words reach the bus in the order the card side pushed them.
- R4: No write cycle starts while the receive FIFO is empty as seen on the bus side (`bus_empty_o` high).
- R5: With no bus acknowledges, `card_full_o` stays low after 15 pushes and rises after the 16th. Pushes while full are dropped. The flag stays high until words drain or receive mode is disabled.
- R6: After `rx_en` falls, the bus cycle ends at the next bus clock edge. `card_full_o` clears within 4 card clocks, and all queued receive words are discarded.
- R7: In transmit mode, acknowledged read data enters the transmit FIFO. No read cycle starts while `bus_full_o` is high. With the card side idle, exactly 16 reads complete and the bus then stays idle.
- R8: `card_dat_o` shows the head word of the transmit FIFO before any pop, and a pop on `card_rd_i` advances to the next word. Popped words come out in memory address order. A pop while `card_empty_o` is high is ignored. Dropping `tx_en` sets `card_empty_o` again within 4 card clocks.
- R9: With both enables high, only write cycles are issued. Transmit reads start only after `rx_en` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus-side clock |
| rst | input | 1 | Asynchronous active-high reset for both domains |
| rx_en | input | 1 | Receive mode enable (bus domain) |
| tx_en | input | 1 | Transmit mode enable (bus domain) |
| base_adr | input | 32 | Byte address of word 0 |
| wb_adr_o | output | 32 | Bus cycle address |
| wb_dat_o | output | 32 | Write data |
| wb_dat_i | input | 32 | Read data |
| wb_we_o | output | 1 | Write cycle marker |
| wb_cyc_o | output | 1 | Cycle active |
| wb_stb_o | output | 1 | Strobe |
| wb_ack_i | input | 1 | Cycle acknowledge |
| bus_full_o | output | 1 | Transmit FIFO full (bus domain) |
| bus_empty_o | output | 1 | Receive FIFO empty (bus domain) |
| card_clk | input | 1 | Card-side clock |
| card_wr_i | input | 1 | Push strobe into the receive FIFO |
| card_dat_i | input | 32 | Pushed word |
| card_rd_i | input | 1 | Pop strobe from the transmit FIFO |
| card_dat_o | output | 32 | Head word of the transmit FIFO |
| card_full_o | output | 1 | Receive FIFO full (card domain) |
| card_empty_o | output | 1 | Transmit FIFO empty (card domain) |

## Verification
The bench uses the default parameters: 32-bit words, a 16-word FIFO depth (`FIFO_AW` = 4) and two synchroniser stages. The shallow depth lets a stalled bus fill the receive FIFO after 16 pushes, and an idle card side fills the transmit FIFO after 16 reads, so both full paths are exercised. The 40-word random receive run carries the 5-bit Gray pointers past their wrap point. The two-stage synchroniser keeps the flush and flag latencies within the 4-card-clock bounds that R6 and R8 check.

// File: rtl/bridge_pkg.sv
`timescale 1ns/1ps
package bridge_pkg;
   typedef enum logic [1:0] {
      M_IDLE  = 2'd0,
      M_WRITE = 2'd1,
      M_READ  = 2'd2
   } mstate_t;
endpackage

// File: rtl/bridge_sync.sv
`timescale 1ns/1ps
module bridge_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         clr,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("bridge_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("bridge_sync: W must be positive");
   end

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or posedge rst) begin
      if (rst)      stg <= '0;
      else if (clr) stg <= '0;
      else          stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/bridge_afifo.sv
`timescale 1ns/1ps
module bridge_afifo #(
   parameter int DW   = 32,
   parameter int AW   = 4,
   parameter int SYNC = 2
) (
   input  logic          wclk,
   input  logic          rst,
   input  logic          wflush,
   input  logic          wr_en,
   input  logic [DW-1:0] wdata,
   output logic          wfull,
   input  logic          rclk,
   input  logic          rflush,
   input  logic          rd_en,
   output logic [DW-1:0] rdata,
   output logic          rempty
);
   localparam int PW    = AW + 1;
   localparam int DEPTH = 1 << AW;

   if (AW < 2) begin : g_bad_aw
      $error("bridge_afifo: AW must be at least 2");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [PW-1:0] wbin, wgray, wbin_nx, rgray_w;
   logic [PW-1:0] rbin, rgray, rbin_nx, wgray_r;
   logic          do_wr, do_rd;

   function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
      return b ^ (b >> 1);
   endfunction

   // write domain
   assign do_wr   = wr_en && !wfull && !wflush;
   assign wbin_nx = wbin + PW'(do_wr);

   always_ff @(posedge wclk or posedge rst) begin
      if (rst) begin
         wbin  <= '0;
         wgray <= '0;
      end else if (wflush) begin
         wbin  <= '0;
         wgray <= '0;
      end else begin
         wbin  <= wbin_nx;
         wgray <= to_gray(wbin_nx);
      end
   end

   always_ff @(posedge wclk) begin
      if (do_wr) mem[wbin[AW-1:0]] <= wdata;
   end

   bridge_sync #(.W(PW), .STAGES(SYNC)) u_r2w (
      .clk(wclk), .rst(rst), .clr(wflush), .d(rgray), .q(rgray_w)
   );

   assign wfull = (wgray == {~rgray_w[PW-1:PW-2], rgray_w[PW-3:0]});

   // read domain
   assign do_rd   = rd_en && !rempty && !rflush;
   assign rbin_nx = rbin + PW'(do_rd);

   always_ff @(posedge rclk or posedge rst) begin
      if (rst) begin
         rbin  <= '0;
         rgray <= '0;
      end else if (rflush) begin
         rbin  <= '0;
         rgray <= '0;
      end else begin
         rbin  <= rbin_nx;
         rgray <= to_gray(rbin_nx);
      end
   end

   bridge_sync #(.W(PW), .STAGES(SYNC)) u_w2r (
      .clk(rclk), .rst(rst), .clr(rflush), .d(wgray), .q(wgray_r)
   );

   assign rempty = (rgray == wgray_r);
   assign rdata  = mem[rbin[AW-1:0]];
endmodule

// File: rtl/bridge_master.sv
`timescale 1ns/1ps
module bridge_master
   import bridge_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int IDX_W  = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rx_en,
   input  logic              tx_en,
   input  logic [ADDR_W-1:0] base_adr,
   input  logic              rx_empty,
   input  logic [DATA_W-1:0] rx_data,
   output logic              rx_pop,
   input  logic              tx_full,
   output logic              tx_push,
   output logic [ADDR_W-1:0] adr_o,
   output logic [DATA_W-1:0] dat_o,
   output logic              we_o,
   output logic              cyc_o,
   output logic              stb_o,
   input  logic              ack_i
);
   localparam int SH = $clog2(DATA_W / 8);

   if (IDX_W + SH > ADDR_W) begin : g_bad_idx
      $error("bridge_master: IDX_W too wide for ADDR_W");
   end

   mstate_t           state;
   logic [IDX_W-1:0]  idx;
   logic [ADDR_W-1:0] next_adr;

   assign next_adr = base_adr + (ADDR_W'(idx) << SH);

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         state <= M_IDLE;
         idx   <= '0;
         adr_o <= '0;
         dat_o <= '0;
      end else begin
         unique case (state)
            M_IDLE: begin
               if (rx_en && !rx_empty) begin
                  state <= M_WRITE;
                  adr_o <= next_adr;
                  dat_o <= rx_data;
               end else if (!rx_en && tx_en && !tx_full) begin
                  state <= M_READ;
                  adr_o <= next_adr;
               end
            end
            M_WRITE: begin
               if (!rx_en) state <= M_IDLE;
               else if (ack_i) begin
                  state <= M_IDLE;
                  idx   <= idx + 1'b1;
               end
            end
            M_READ: begin
               if (!tx_en) state <= M_IDLE;
               else if (ack_i) begin
                  state <= M_IDLE;
                  idx   <= idx + 1'b1;
               end
            end
            default: state <= M_IDLE;
         endcase
         if (!rx_en && !tx_en) idx <= '0;
      end
   end

   assign cyc_o   = (state != M_IDLE);
   assign stb_o   = (state != M_IDLE);
   assign we_o    = (state == M_WRITE);
   assign rx_pop  = (state == M_WRITE) && rx_en && ack_i;
   assign tx_push = (state == M_READ) && tx_en && ack_i;
endmodule

// File: rtl/bridge_dma.sv
`timescale 1ns/1ps
module bridge_dma #(
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter int FIFO_AW     = 4,
   parameter int SYNC_STAGES = 2,
   parameter int IDX_W       = 16
) (
   input  logic              bus_clk,
   input  logic              rst,
   input  logic              rx_en,
   input  logic              tx_en,
   input  logic [ADDR_W-1:0] base_adr,
   output logic [ADDR_W-1:0] wb_adr_o,
   output logic [DATA_W-1:0] wb_dat_o,
   input  logic [DATA_W-1:0] wb_dat_i,
   output logic              wb_we_o,
   output logic              wb_cyc_o,
   output logic              wb_stb_o,
   input  logic              wb_ack_i,
   output logic              bus_full_o,
   output logic              bus_empty_o,
   input  logic              card_clk,
   input  logic              card_wr_i,
   input  logic [DATA_W-1:0] card_dat_i,
   input  logic              card_rd_i,
   output logic [DATA_W-1:0] card_dat_o,
   output logic              card_full_o,
   output logic              card_empty_o
);
   if (DATA_W % 8 != 0) begin : g_bad_dw
      $error("bridge_dma: DATA_W must be a whole number of bytes");
   end

   logic [1:0]        card_en;
   logic [DATA_W-1:0] rx_head;
   logic              rx_pop, tx_push;

   bridge_sync #(.W(2), .STAGES(SYNC_STAGES)) u_en_sync (
      .clk(card_clk), .rst(rst), .clr(1'b0),
      .d({rx_en, tx_en}), .q(card_en)
   );

   bridge_afifo #(.DW(DATA_W), .AW(FIFO_AW), .SYNC(SYNC_STAGES)) u_rx_fifo (
      .wclk(card_clk), .rst(rst), .wflush(!card_en[1]),
      .wr_en(card_wr_i), .wdata(card_dat_i), .wfull(card_full_o),
      .rclk(bus_clk), .rflush(!rx_en),
      .rd_en(rx_pop), .rdata(rx_head), .rempty(bus_empty_o)
   );

   bridge_afifo #(.DW(DATA_W), .AW(FIFO_AW), .SYNC(SYNC_STAGES)) u_tx_fifo (
      .wclk(bus_clk), .rst(rst), .wflush(!tx_en),
      .wr_en(tx_push), .wdata(wb_dat_i), .wfull(bus_full_o),
      .rclk(card_clk), .rflush(!card_en[0]),
      .rd_en(card_rd_i), .rdata(card_dat_o), .rempty(card_empty_o)
   );

   bridge_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_master (
      .clk(bus_clk), .rst(rst), .rx_en(rx_en), .tx_en(tx_en),
      .base_adr(base_adr),
      .rx_empty(bus_empty_o), .rx_data(rx_head), .rx_pop(rx_pop),
      .tx_full(bus_full_o), .tx_push(tx_push),
      .adr_o(wb_adr_o), .dat_o(wb_dat_o), .we_o(wb_we_o),
      .cyc_o(wb_cyc_o), .stb_o(wb_stb_o), .ack_i(wb_ack_i)
   );
endmodule

// File: rtl/bridge_dma_chk.sv
`timescale 1ns/1ps
module bridge_dma_chk #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input logic              bus_clk,
   input logic              rst,
   input logic              rx_en,
   input logic              tx_en,
   input logic [ADDR_W-1:0] base_adr,
   input logic [ADDR_W-1:0] wb_adr_o,
   input logic [DATA_W-1:0] wb_dat_o,
   input logic              wb_we_o,
   input logic              wb_cyc_o,
   input logic              wb_stb_o,
   input logic              wb_ack_i,
   input logic              bus_full_o,
   input logic              bus_empty_o
);
   localparam int SH = $clog2(DATA_W / 8);

   logic [ADDR_W-1:0] n_seen;

   always_ff @(posedge bus_clk or posedge rst) begin
      if (rst)                   n_seen <= '0;
      else if (!rx_en && !tx_en) n_seen <= '0;
      else if (wb_cyc_o && wb_ack_i && (wb_we_o ? rx_en : tx_en))
         n_seen <= n_seen + 1'b1;
   end

   p_we_in_cycle_r3: assert property (@(posedge bus_clk) disable iff (rst)
      wb_we_o |-> (wb_cyc_o && wb_stb_o));

   p_hold_until_ack_r3: assert property (@(posedge bus_clk) disable iff (rst)
      (wb_cyc_o && wb_we_o && !wb_ack_i && rx_en)
      |=> (wb_we_o && $stable(wb_adr_o) && $stable(wb_dat_o)));

   p_no_write_when_empty_r4: assert property (@(posedge bus_clk) disable iff (rst)
      ($rose(wb_cyc_o) && wb_we_o) |-> !bus_empty_o);

   p_no_read_when_full_r7: assert property (@(posedge bus_clk) disable iff (rst)
      ($rose(wb_cyc_o) && !wb_we_o) |-> !bus_full_o);

   p_rx_abort_r6: assert property (@(posedge bus_clk) disable iff (rst)
      (wb_we_o && !rx_en) |=> !wb_cyc_o);

   p_idle_when_off_r6: assert property (@(posedge bus_clk) disable iff (rst)
      (!rx_en && !tx_en) |=> !wb_cyc_o);

   p_addr_step_r2: assert property (@(posedge bus_clk) disable iff (rst)
      $rose(wb_cyc_o) |-> (wb_adr_o == base_adr + (n_seen << SH)));
endmodule

bind bridge_dma bridge_dma_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_bridge_dma.sv
`timescale 1ns/1ps
module sim_bridge_dma;
   logic        bus_clk = 1'b0, card_clk = 1'b0, rst = 1'b1;
   logic        rx_en = 1'b0, tx_en = 1'b0;
   logic [31:0] base_adr = '0;
   logic [31:0] wb_adr_o, wb_dat_o, card_dat_o;
   logic [31:0] wb_dat_i = '0, card_dat_i = '0;
   logic        wb_we_o, wb_cyc_o, wb_stb_o, wb_ack_i = 1'b0;
   logic        bus_full_o, bus_empty_o, card_full_o, card_empty_o;
   logic        card_wr_i = 1'b0, card_rd_i = 1'b0;

   int n_tests = 0, n_fail = 0;

   always #2.5 bus_clk  = ~bus_clk;   // 200 MHz
   always #6.5 card_clk = ~card_clk;  // unrelated slower card clock

   bridge_dma u0 (.*);

   function automatic logic [31:0] memword(input logic [31:0] a);
      return (a * 32'h0100_0193) ^ 32'h5BD1_E995;
   endfunction

   // bus slave model
   logic        stall = 1'b0;
   int          wait_max = 3, wait_now = 0, wcnt = 0;
   int          n_wr = 0, n_rd = 0;
   logic [31:0] wlog_dat [128];
   logic [31:0] wlog_adr [128];
   logic [31:0] rlog_adr [256];

   always @(posedge bus_clk) begin
      if (rst) begin
         wb_ack_i <= 1'b0;
         wcnt     <= 0;
      end else if (wb_ack_i) begin
         wb_ack_i <= 1'b0;
         wcnt     <= 0;
      end else if (wb_cyc_o && wb_stb_o && !stall) begin
         if (wcnt >= wait_now) begin
            wb_ack_i <= 1'b1;
            wcnt     <= 0;
            wait_now <= $urandom_range(0, wait_max);
            if (wb_we_o) begin
               wlog_dat[n_wr] <= wb_dat_o;
               wlog_adr[n_wr] <= wb_adr_o;
               n_wr           <= n_wr + 1;
            end else begin
               wb_dat_i       <= memword(wb_adr_o);
               rlog_adr[n_rd] <= wb_adr_o;
               n_rd           <= n_rd + 1;
            end
         end else wcnt <= wcnt + 1;
      end else wcnt <= 0;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_wait(input int n);
      repeat (n) @(negedge bus_clk);
   endtask

   task automatic card_wait(input int n);
      repeat (n) @(negedge card_clk);
   endtask

   task automatic card_push(input logic [31:0] d, input bit obey_full);
      @(negedge card_clk);
      if (obey_full)
         for (int i = 0; i < 1000 && card_full_o; i++) @(negedge card_clk);
      card_wr_i  = 1'b1;
      card_dat_i = d;
      @(negedge card_clk);
      card_wr_i  = 1'b0;
   endtask

   task automatic card_pop(output logic [31:0] d, input bit wait_data);
      @(negedge card_clk);
      if (wait_data)
         for (int i = 0; i < 1000 && card_empty_o; i++) @(negedge card_clk);
      d         = card_dat_o;
      card_rd_i = 1'b1;
      @(negedge card_clk);
      card_rd_i = 1'b0;
   endtask

   task automatic wait_writes(input int target);
      for (int i = 0; i < 5000 && n_wr < target; i++) @(negedge bus_clk);
      for (int i = 0; i < 100 && wb_cyc_o; i++) @(negedge bus_clk);
   endtask

   initial begin
      repeat (150000) @(posedge bus_clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] exp_q [64];
      logic [31:0] got;
      logic [31:0] b;
      int          w0, r0;
      void'($urandom(32'd20240611));

      bus_wait(4);
      rst = 1'b0;
      bus_wait(1);
      // R1 reset state
      chk("R1 cyc", wb_cyc_o, 0);
      chk("R1 we", wb_we_o, 0);
      chk("R1 card_empty", card_empty_o, 1);
      chk("R1 bus_full", bus_full_o, 0);
      chk("R1 card_full", card_full_o, 0);
      chk("R1 bus_empty", bus_empty_o, 1);

      // R3/R2: random receive stream with random acknowledge latency
      b = 32'h1000_0000 | ($urandom & 32'h000F_FFFC);
      base_adr = b;
      rx_en = 1'b1;
      card_wait(5);
      for (int k = 0; k < 40; k++) begin
         exp_q[k] = $urandom;
         if ($urandom_range(0, 1) == 1) card_wait(1);
         card_push(exp_q[k], 1'b1);
      end
      wait_writes(40);
      chk("R3 write count", n_wr, 40);
      for (int k = 0; k < 40; k++) begin
         chk("R3 write data", wlog_dat[k], exp_q[k]);
         chk("R2 write addr", wlog_adr[k], b + 4 * k);
      end
      // R4: drained FIFO, enable still high: no new cycle
      for (int i = 0; i < 20; i++) begin
         bus_wait(1);
         if (wb_cyc_o) begin
            chk("R4 idle when empty", wb_cyc_o, 0);
            break;
         end
      end
      chk("R4 bus_empty", bus_empty_o, 1);
      rx_en = 1'b0;
      card_wait(5);

      // R5/R6: stalled bus fills the receive FIFO
      b = 32'h2000_0000 | ($urandom & 32'h000F_FFFC);
      base_adr = b;
      stall = 1'b1;
      w0 = n_wr;
      rx_en = 1'b1;
      card_wait(5);
      for (int k = 0; k < 15; k++) card_push($urandom, 1'b0);
      chk("R5 not full at 15", card_full_o, 0);
      card_push($urandom, 1'b0);
      chk("R5 full at 16", card_full_o, 1);
      for (int k = 0; k < 3; k++) card_push($urandom, 1'b0);
      card_wait(10);
      chk("R5 full persists", card_full_o, 1);
      chk("R5 cycle pending", wb_cyc_o, 1);
      @(negedge bus_clk);
      rx_en = 1'b0;
      bus_wait(1);
      chk("R6 cyc drop", wb_cyc_o, 0);
      chk("R6 we drop", wb_we_o, 0);
      card_wait(4);
      chk("R6 card_full clears", card_full_o, 0);
      chk("R6 bus_empty", bus_empty_o, 1);
      stall = 1'b0;
      rx_en = 1'b1;
      card_wait(5);
      bus_wait(20);
      chk("R6 discarded words", n_wr - w0, 0);
      chk("R6 still empty", bus_empty_o, 1);

      // R5: fill while stalled, then drain; dropped extra pushes; index restarted
      stall = 1'b1;
      for (int k = 0; k < 16; k++) begin
         exp_q[k] = $urandom;
         card_push(exp_q[k], 1'b0);
      end
      chk("R5 full again", card_full_o, 1);
      card_push(32'hDEAD_0001, 1'b0);
      card_push(32'hDEAD_0002, 1'b0);
      stall = 1'b0;
      wait_writes(w0 + 16);
      bus_wait(40);
      chk("R5 drained count", n_wr - w0, 16);
      for (int k = 0; k < 16; k++) begin
         chk("R5 drained data", wlog_dat[w0 + k], exp_q[k]);
         chk("R2 restart addr", wlog_adr[w0 + k], b + 4 * k);
      end
      card_wait(4);
      chk("R5 full cleared after drain", card_full_o, 0);
      rx_en = 1'b0;
      card_wait(5);

      // R7/R8: transmit fills while card idle, then card pops in order
      b = 32'h3000_0000 | ($urandom & 32'h000F_FFFC);
      base_adr = b;
      stall = 1'b1;
      r0 = n_rd;
      tx_en = 1'b1;
      card_wait(5);
      chk("R8 empty before data", card_empty_o, 1);
      card_pop(got, 1'b0);                  // ignored pop on empty
      stall = 1'b0;
      for (int i = 0; i < 2000 && !bus_full_o; i++) @(negedge bus_clk);
      bus_wait(30);
      chk("R7 reads until full", n_rd - r0, 16);
      chk("R7 idle when full", wb_cyc_o, 0);
      chk("R7 bus_full", bus_full_o, 1);
      chk("R8 card has data", card_empty_o, 0);
      chk("R8 head before pop", card_dat_o, memword(b));
      for (int k = 0; k < 30; k++) begin
         if ($urandom_range(0, 2) == 0) card_wait($urandom_range(1, 3));
         card_pop(got, 1'b1);
         chk("R8 pop order", got, memword(b + 4 * k));
      end
      for (int k = 0; k < 30; k++) chk("R2 read addr", rlog_adr[r0 + k], b + 4 * k);
      tx_en = 1'b0;
      card_wait(4);
      chk("R8 flush empty", card_empty_o, 1);
      bus_wait(4);
      chk("R8 bus_full cleared", bus_full_o, 0);

      // R9: both enables high -> receive only; then transmit continues index
      b = 32'h4000_0000 | ($urandom & 32'h000F_FFFC);
      base_adr = b;
      w0 = n_wr;
      r0 = n_rd;
      rx_en = 1'b1;
      tx_en = 1'b1;
      card_wait(5);
      for (int k = 0; k < 5; k++) begin
         exp_q[k] = $urandom;
         card_push(exp_q[k], 1'b1);
      end
      wait_writes(w0 + 5);
      bus_wait(30);
      chk("R9 writes", n_wr - w0, 5);
      chk("R9 no reads", n_rd - r0, 0);
      for (int k = 0; k < 5; k++) chk("R9 write data", wlog_dat[w0 + k], exp_q[k]);
      rx_en = 1'b0;
      for (int i = 0; i < 2000 && !bus_full_o; i++) @(negedge bus_clk);
      bus_wait(30);
      chk("R9 reads after rx off", n_rd - r0, 16);
      chk("R2 index continues", rlog_adr[r0], b + 4 * 5);
      card_pop(got, 1'b1);
      chk("R8 first tx word", got, memword(b + 4 * 5));
      tx_en = 1'b0;
      card_wait(5);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule